// File: doc/BRIEF.md
# Bit-Sliced Accumulator ALU with Programmable Logic Stage

This block is the data path of a small accumulator machine. It is eight bits wide and made of two identical four-bit slices. Each slice holds part of an accumulator register (operand A) and part of a data register (operand B). The data register is filled from the data bus. The accumulator is filled from the ALU result, so every store and every operand read passes through the ALU as a pass-through function. Each clock enable acts on the rising clock edge.

Each result bit has two stages. The first is a programmable logic unit. A four-bit function code is used as the truth table of a two-input function, so it can give any of the sixteen functions of A and B. The second stage is a ripple carry chain that is carried active-low inside the block. An add-enable bit turns this stage on or off. With the bit set and the code set to exclusive-or, the block adds. With the bit clear, the result is the logic-stage output alone. A control sequencer outside the block drives the function code, the add-enable bit, the carry input and the two load strobes.

Top module: `sliced_alu`

## Requirements
- R1: After reset, both the accumulator and the data register hold zero. Pass-A (code 1100) and pass-B (code 1010) then both give result 0x00.
- R2: When `dat_load` is high at a rising edge, the data register takes `data_in`. When `dat_load` is low, it keeps its value whatever `data_in` does.
- R3: When `acc_load` is high at a rising edge, the accumulator takes the current `result`. When `acc_load` is low, it keeps its value.
- R4: With `ctrl` = 1_0110 (add enabled, exclusive-or code), {`carry_out`,`result`} equals A + B + `carry_in`, for `carry_in` 0 and 1.
- R5: With `ctrl[4]` = 0, each result bit i equals `ctrl[{A[i],B[i]}]`, where `ctrl[0]` is the output for A=0,B=0, `ctrl[1]` for A=0,B=1, `ctrl[2]` for A=1,B=0 and `ctrl[3]` for A=1,B=1. This holds for all sixteen codes.
- R6: Code 0001 with `ctrl[4]` = 0 gives the bitwise NOR of A and B.
- R7: Code 1100 with `ctrl[4]` = 0 gives A, and code 1010 gives B.
- R8: During an add, the carry ripples across the boundary between the two slices (for example 0x0F + 0x01 = 0x10).
- R9: With `ctrl[4]` = 0, no bit generates a carry. `carry_out` is 1 only when `carry_in` is 1 and every logic-stage bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| carry_in | input | 1 | Carry into bit 0, active-high |
| acc_load | input | 1 | Accumulator load enable |
| dat_load | input | 1 | Data register load enable |
| ctrl | input | 5 | Bits [3:0] are the function truth table; bit 4 enables the carry chain |
| data_in | input | 8 | Data bus into the data register |
| result | output | 8 | ALU result |
| carry_out | output | 1 | Carry out of bit 7, active-high |

## Verification
The accumulator can only be filled through the ALU. To place a chosen value in A, the bench first puts it in the data register, then copies it across with the pass-B code and an accumulator load, and only then loads the real B operand. Every vector is reached by this three-step sequence. The carry crossing between slices and the carry passing through an all-ones logic result with add disabled are set up by choosing operands that make the intended bits propagate.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FUNC_W = 4;
  localparam int CTRL_W = FUNC_W + 1;

  typedef struct packed {
    logic              add_en;
    logic [FUNC_W-1:0] func;
  } alu_ctrl_t;

  localparam logic [FUNC_W-1:0] FN_XOR = 4'b0110;
endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import alu_pkg::*;
(
  input  logic              a,
  input  logic              b,
  input  logic [FUNC_W-1:0] func,
  input  logic              add_en,
  input  logic              nc_in,
  output logic              y,
  output logic              nc_out
);
  logic c_hi, prop, gen;

  always_comb begin
    c_hi   = ~nc_in;
    prop   = func[{a, b}];
    gen    = a & b & add_en;
    y      = prop ^ (c_hi & add_en);
    nc_out = ~(gen | (prop & c_hi));
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_ld,
  input  logic              dat_ld,
  input  logic [FUNC_W-1:0] func,
  input  logic              add_en,
  input  logic [W-1:0]      bus_in,
  input  logic              nc_in,
  output logic [W-1:0]      y,
  output logic              nc_out,
  output logic [W-1:0]      op_a,
  output logic [W-1:0]      op_b
);
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] dat_q, dat_d;
  logic [W:0]   nc;

  assign nc[0] = nc_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    alu_bit_cell u_cell (
      .a      (acc_q[i]),
      .b      (dat_q[i]),
      .func   (func),
      .add_en (add_en),
      .nc_in  (nc[i]),
      .y      (y[i]),
      .nc_out (nc[i+1])
    );
  end

  assign nc_out = nc[W];
  assign op_a   = acc_q;
  assign op_b   = dat_q;

  always_comb begin
    acc_d = acc_q;
    dat_d = dat_q;
    if (acc_ld) acc_d = y;
    if (dat_ld) dat_d = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      dat_q <= '0;
    end else begin
      acc_q <= acc_d;
      dat_q <= dat_d;
    end
  end

  assert_dat_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && dat_ld) |=> (dat_q == $past(bus_in)));
  assert_dat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !dat_ld) |=> $stable(dat_q));
  assert_acc_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && acc_ld) |=> (acc_q == $past(y)));
  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !acc_ld) |=> $stable(acc_q));
endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
  import alu_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int SLICE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carry_in,
  input  logic              acc_load,
  input  logic              dat_load,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [WIDTH-1:0]  data_in,
  output logic [WIDTH-1:0]  result,
  output logic              carry_out
);
  localparam int NSLICE = WIDTH / SLICE_W;

  alu_ctrl_t        ctl;
  logic             rst_s_n;
  logic [NSLICE:0]  nc_chain;
  logic [WIDTH-1:0] acc_v, dat_v;

  assign ctl = alu_ctrl_t'(ctrl);

  alu_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign nc_chain[0] = ~carry_in;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    alu_slice #(.W(SLICE_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .acc_ld (acc_load),
      .dat_ld (dat_load),
      .func   (ctl.func),
      .add_en (ctl.add_en),
      .bus_in (data_in[s*SLICE_W +: SLICE_W]),
      .nc_in  (nc_chain[s]),
      .y      (result[s*SLICE_W +: SLICE_W]),
      .nc_out (nc_chain[s+1]),
      .op_a   (acc_v[s*SLICE_W +: SLICE_W]),
      .op_b   (dat_v[s*SLICE_W +: SLICE_W])
    );
  end

  assign carry_out = ~nc_chain[NSLICE];

  function automatic logic [WIDTH-1:0] table_ref(input logic [FUNC_W-1:0] f,
                                                 input logic [WIDTH-1:0] x,
                                                 input logic [WIDTH-1:0] z);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = f[{x[i], z[i]}];
    return r;
  endfunction

  assert_add_sum_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctl.add_en && ctl.func == FN_XOR) |->
      ({carry_out, result} == ({1'b0, acc_v} + {1'b0, dat_v} + (WIDTH+1)'(carry_in))));
  assert_logic_only_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ctl.add_en |-> (result == table_ref(ctl.func, acc_v, dat_v)));
  assert_no_generate_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ctl.add_en |-> (carry_out == (carry_in && (&result))));
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_s_n |-> (acc_v == '0 && dat_v == '0));
endmodule

// File: tb/sliced_alu_tb_top.sv
module sliced_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       carry_in;
  logic       acc_load;
  logic       dat_load;
  logic [4:0] ctrl;
  logic [7:0] data_in;
  logic [7:0] result;
  logic       carry_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sliced_alu dut_i (
    .clk(clk), .rst_n(rst_n), .carry_in(carry_in), .acc_load(acc_load),
    .dat_load(dat_load), .ctrl(ctrl), .data_in(data_in),
    .result(result), .carry_out(carry_out)
  );

  // {ctrl, cin, A, B, expected result, expected carry}
  localparam int NV = 12;
  localparam logic [30:0] VEC [NV] = '{
    {5'b10110, 1'b0, 8'h03, 8'h05, 8'h08, 1'b0},  // R4
    {5'b10110, 1'b1, 8'h03, 8'h05, 8'h09, 1'b0},  // R4
    {5'b10110, 1'b0, 8'hFF, 8'h01, 8'h00, 1'b1},  // R4
    {5'b10110, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b1},  // R4
    {5'b10110, 1'b0, 8'h0F, 8'h01, 8'h10, 1'b0},  // R8
    {5'b10110, 1'b1, 8'h80, 8'h80, 8'h01, 1'b1},  // R4
    {5'b10110, 1'b1, 8'h7F, 8'h80, 8'h00, 1'b1},  // R8
    {5'b00001, 1'b0, 8'hF0, 8'h3C, 8'h03, 1'b0},  // R6
    {5'b01100, 1'b0, 8'hA5, 8'h5A, 8'hA5, 1'b0},  // R7
    {5'b01010, 1'b0, 8'hA5, 8'h5A, 8'h5A, 1'b0},  // R7
    {5'b01111, 1'b1, 8'h12, 8'h34, 8'hFF, 1'b1},  // R9
    {5'b01000, 1'b1, 8'hFF, 8'h0F, 8'h0F, 1'b0}   // R9
  };

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load_ops(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); data_in = a; dat_load = 1'b1; acc_load = 1'b0;
    @(negedge clk); dat_load = 1'b0; ctrl = 5'b01010; acc_load = 1'b1;
    @(negedge clk); acc_load = 1'b0; data_in = b; dat_load = 1'b1;
    @(negedge clk); dat_load = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; carry_in = 1'b0; acc_load = 1'b0; dat_load = 1'b0;
    ctrl = 5'b01100; data_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state seen through pass-A and pass-B
    ctrl = 5'b01100; #5; check("R1 passA", {1'b0, result}, 9'h000);
    ctrl = 5'b01010; #5; check("R1 passB", {1'b0, result}, 9'h000);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      load_ops(VEC[v][24:17], VEC[v][16:9]);
      ctrl = VEC[v][30:26]; carry_in = VEC[v][25];
      #5;
      check("R4/R6/R7/R8/R9 vector", {carry_out, result}, {VEC[v][0], VEC[v][8:1]});
    end

    // R5: all sixteen codes with add disabled
    load_ops(8'hCA, 8'hAC);
    carry_in = 1'b0;
    for (int f = 0; f < 16; f++) begin
      logic [7:0] exp;
      for (int i = 0; i < 8; i++) exp[i] = f[{1'b0, 8'hCA >> i & 8'h01 ? 1'b1 : 1'b0, (8'hAC >> i) & 1 ? 1'b1 : 1'b0}];
      @(negedge clk); ctrl = {1'b0, 4'(f)}; #5;
      check("R5 code", {1'b0, result}, {1'b0, exp});
    end

    // R2: data register holds when dat_load is low
    @(negedge clk); ctrl = 5'b01010; data_in = 8'h99; dat_load = 1'b0;
    @(negedge clk); data_in = 8'h11; #5;
    check("R2 hold", {1'b0, result}, 9'h0AC);
    @(negedge clk); dat_load = 1'b1; data_in = 8'h3E;
    @(negedge clk); dat_load = 1'b0; #5;
    check("R2 load", {1'b0, result}, 9'h03E);

    // R3: accumulator takes sum, then holds
    load_ops(8'h21, 8'h13);
    ctrl = 5'b10110; carry_in = 1'b0; acc_load = 1'b1;
    @(negedge clk); acc_load = 1'b0; ctrl = 5'b01100; #5;
    check("R3 load", {1'b0, result}, 9'h034);
    @(negedge clk); ctrl = 5'b01000; @(negedge clk); ctrl = 5'b01100; #5;
    check("R3 hold", {1'b0, result}, 9'h034);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule